// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a packet DMA engine. Frame bytes arrive one per beat on a plain byte stream that carries start, end and error markers. The block places each byte into fixed-size receive buffers. A ring of descriptors, held in registers inside the block, describes those buffers. Each descriptor pairs a constant buffer pointer word with a status word.

Every byte that is kept leaves the block as a one-byte memory write with a full address. When a buffer fills, or a frame ends, the block closes the buffer's descriptor. Closing sets the ownership flag and records the first-piece and last-piece markers. On the last piece it also records the whole frame length and the error marker. The ring pointer then moves to the next descriptor, or back to descriptor 0 after the one that carries the wrap flag. A frame can therefore cross the wrap point.

Software reads any descriptor through an index port and hands a buffer back by pulsing a free strobe. If the next buffer still belongs to software when a new one is needed, the rest of the frame is thrown away and a sticky "no buffer" flag is raised. Turning reception off abandons any frame in progress and sends the pointer back to descriptor 0.

The control is a three-state machine:
- **ST_IDLE** waits for a start beat.
- **ST_FILL** stores bytes.
- **ST_DROP** discards bytes up to the end beat.

Its transitions are:
- **T_START**: ST_IDLE to ST_FILL, on a stored start beat without end.
- **T_SHORT**: ST_IDLE to ST_IDLE, on a start beat that also ends the frame.
- **T_END**: ST_FILL to ST_IDLE, on a stored end beat.
- **T_BLOCK**: ST_IDLE or ST_FILL to ST_DROP, when the needed buffer is owned and the beat is not an end beat.
- **T_BLOCK_END**: to ST_IDLE, when the needed buffer is owned and the beat is an end beat.
- **T_FLUSH**: ST_DROP to ST_IDLE, on an end beat.
- **T_OFF**: any state to ST_IDLE, while reception is disabled.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, every descriptor's status word is 0. Its pointer word is BASE_ADDR + i*BUF_BYTES, with bit 0 (owned) clear and bit 1 (wrap) set only for descriptor DEPTH-1. The nobuf flag is 0.
- R2: A stored byte appears one cycle after its beat as mem_we=1, with mem_addr = BASE_ADDR + d*BUF_BYTES + k and mem_wdata equal to the byte. Here d is the current descriptor and k is the byte's position within that buffer.
- R3: When a buffer takes its BUF_BYTES-th byte and that byte is not an end beat, its descriptor is closed. Closing sets the owned bit. The status word has length field [12:0] = 0, bit 15 (last) = 0, and bit 14 (first) = 1 only for the frame's first buffer.
- R4: The buffer that takes a frame's end beat is closed with the owned bit set, bit 15 = 1, and [12:0] equal to the frame's total stored byte count. Bit 14 is set if that buffer is also the frame's first.
- R5: After closing the descriptor whose wrap bit is set, the next buffer used is descriptor 0, including in the middle of a frame.
- R6: A byte that needs a new buffer whose descriptor is owned is not written, and neither is any later byte of that frame. The nobuf flag is set. The ring pointer does not move, so the next frame starts at that same descriptor once it is freed.
- R7: nobuf stays 1 until a cycle with sw_nobuf_clr=1 and no new blocking event, after which it reads 0.
- R8: If the end beat carries s_err=1, the closing status word has bit 13 set. Otherwise bit 13 is 0.
- R9: A sw_free pulse clears the owned bit of descriptor sw_idx and leaves that descriptor's status word and all other descriptors unchanged.
- R10: While rx_en=0, no beat is written and a frame in progress is abandoned. The next frame after re-enabling starts at descriptor 0, offset 0.
- R11: Beats with s_valid=1 outside a frame (s_sof=0 while idle) produce no write and change no descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Reception enable |
| s_valid | input | 1 | Byte beat valid |
| s_data | input | 8 | Byte value |
| s_sof | input | 1 | Beat is the first byte of a frame |
| s_eof | input | 1 | Beat is the last byte of a frame |
| s_err | input | 1 | Frame error marker, sampled on the end beat |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | 32 | Buffer byte address |
| mem_wdata | output | 8 | Buffer byte value |
| sw_idx | input | $clog2(DEPTH) | Descriptor index for software read and free |
| sw_addr_word | output | 32 | Pointer word of descriptor sw_idx |
| sw_stat_word | output | 32 | Status word of descriptor sw_idx |
| sw_free | input | 1 | Return descriptor sw_idx to hardware |
| sw_nobuf_clr | input | 1 | Clear the nobuf flag |
| nobuf | output | 1 | Sticky flag: a frame was cut for lack of a buffer |

## Verification
Several faults show up on mem_addr in the cycle after the affected byte:
- a wrong ring pointer;
- a wrong buffer offset;
- a missed wrap.

A stale frame length or a stale first-piece marker stays hidden until the closing status word is read back through the software port. An owned-bit check that fails shows up either way: as a write that should not occur in the cycle after the blocked beat, or as nobuf staying 0. A state machine left in the fill or drop state after an end beat shows up on the next frame, as missing writes or as writes that should not occur.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int OWN_BIT  = 0;
    localparam int WRAP_BIT = 1;
    localparam int ERR_BIT  = 13;
    localparam int FIRST_BIT = 14;
    localparam int LAST_BIT = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DROP = 2'd2
    } fill_state_t;
endpackage

// File: rtl/rxr_desc_ring.sv
module rxr_desc_ring #(
    parameter int          DEPTH     = 8,
    parameter int          BUF_BYTES = 128,
    parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
    parameter int          IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_en,
    input  logic [IDX_W-1:0] close_idx,
    input  logic [31:0]      close_stat,
    input  logic             free_en,
    input  logic [IDX_W-1:0] free_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_addr_word,
    output logic [31:0]      rd_stat_word,
    output logic [DEPTH-1:0] used_vec,
    output logic [DEPTH-1:0] wrap_vec
);
    import rxr_pkg::*;

    logic [31:0] addr_arr [DEPTH];
    logic [31:0] stat_arr [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_desc
        localparam logic [31:0] PTR = BASE_ADDR + 32'(i * BUF_BYTES);
        localparam logic        WRP = (i == DEPTH - 1);
        logic        own_q;
        logic [31:0] stat_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                own_q  <= 1'b0;
                stat_q <= '0;
            end else begin
                if (free_en && free_idx == IDX_W'(i)) own_q <= 1'b0;
                if (close_en && close_idx == IDX_W'(i)) begin
                    own_q  <= 1'b1;
                    stat_q <= close_stat;
                end
            end
        end

        always_comb begin
            addr_arr[i]           = PTR;
            addr_arr[i][WRAP_BIT] = WRP;
            addr_arr[i][OWN_BIT]  = own_q;
        end
        assign stat_arr[i] = stat_q;
        assign used_vec[i] = own_q;
        assign wrap_vec[i] = WRP;
    end

    assign rd_addr_word = addr_arr[rd_idx];
    assign rd_stat_word = stat_arr[rd_idx];

    // R6: hardware never closes a descriptor that software still owns
    p_no_overwrite_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
        close_en |-> !used_vec[close_idx]);

    // R9: a free request leaves the descriptor unowned unless hardware reclaims it
    p_free_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en && !(close_en && close_idx == free_idx)) |=> !used_vec[$past(free_idx)]);
endmodule

// File: rtl/rxr_fill_fsm.sv
module rxr_fill_fsm #(
    parameter int          DEPTH     = 8,
    parameter int          BUF_BYTES = 128,
    parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
    parameter int          IDX_W     = 3,
    parameter int          LEN_W     = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    input  logic             s_sof,
    input  logic             s_eof,
    input  logic             s_err,
    input  logic [DEPTH-1:0] used_vec,
    input  logic [DEPTH-1:0] wrap_vec,
    input  logic             nobuf_clr,
    output logic             close_en,
    output logic [IDX_W-1:0] close_idx,
    output logic [31:0]      close_stat,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             nobuf
);
    import rxr_pkg::*;

    localparam int OFF_W = $clog2(BUF_BYTES);

    fill_state_t      state_q, state_d;
    logic [IDX_W-1:0] wp_q;
    logic [OFF_W-1:0] off_q;
    logic [LEN_W-1:0] len_q;
    logic             first_q;

    logic             take, blocked, store, buf_end, first_now;
    logic [LEN_W-1:0] len_now;
    logic [IDX_W-1:0] wp_next;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control
    always_comb begin
        take      = 1'b0;
        first_now = 1'b0;
        len_now   = len_q + LEN_W'(1);
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                take      = rx_en && s_valid && s_sof;
                first_now = 1'b1;
                len_now   = LEN_W'(1);
            end
            ST_FILL: begin
                take      = rx_en && s_valid;
                first_now = first_q;
            end
            ST_DROP: begin
                if (s_valid && s_eof) state_d = ST_IDLE;   // T_FLUSH
            end
            default: state_d = ST_IDLE;
        endcase
        blocked = take && (off_q == '0) && used_vec[wp_q];
        store   = take && !blocked;
        buf_end = store && (s_eof || off_q == OFF_W'(BUF_BYTES - 1));
        if (blocked)    state_d = s_eof ? ST_IDLE : ST_DROP; // T_BLOCK / T_BLOCK_END
        else if (store) state_d = s_eof ? ST_IDLE : ST_FILL; // T_SHORT / T_END / T_START
        if (!rx_en)     state_d = ST_IDLE;                   // T_OFF
        wp_next = wrap_vec[wp_q] ? '0 : wp_q + IDX_W'(1);

        close_en   = buf_end;
        close_idx  = wp_q;
        close_stat = '0;
        close_stat[FIRST_BIT] = first_now;
        if (s_eof) begin
            close_stat[LAST_BIT]  = 1'b1;
            close_stat[ERR_BIT]   = s_err;
            close_stat[LEN_W-1:0] = len_now;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q      <= '0;
            off_q     <= '0;
            len_q     <= '0;
            first_q   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            nobuf     <= 1'b0;
        end else begin
            nobuf  <= (nobuf && !nobuf_clr) || blocked;
            mem_we <= store;
            if (store) begin
                mem_addr  <= BASE_ADDR + 32'(wp_q) * 32'(BUF_BYTES) + 32'(off_q);
                mem_wdata <= s_data;
                len_q     <= len_now;
                first_q   <= buf_end ? 1'b0 : first_now;
                off_q     <= buf_end ? '0 : off_q + OFF_W'(1);
            end
            if (buf_end) wp_q <= wp_next;
            if (!rx_en) begin
                wp_q  <= '0;
                off_q <= '0;
            end
        end
    end

    // R7: the no-buffer flag holds until cleared
    p_nobuf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nobuf && !nobuf_clr) |=> nobuf);

    // R10: nothing is written while reception is off
    p_no_write_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !mem_we);

    // R2: every byte write lands inside the ring's buffer area
    p_addr_in_ring_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= BASE_ADDR &&
                    mem_addr < BASE_ADDR + 32'(DEPTH) * 32'(BUF_BYTES)));

    // R11: a stray beat between frames writes nothing
    p_idle_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !s_sof) |=> !mem_we);
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
    parameter int          DEPTH     = 8,
    parameter int          BUF_BYTES = 128,
    parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
    parameter int          LEN_W     = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_en,
    input  logic                       s_valid,
    input  logic [7:0]                 s_data,
    input  logic                       s_sof,
    input  logic                       s_eof,
    input  logic                       s_err,
    output logic                       mem_we,
    output logic [31:0]                mem_addr,
    output logic [7:0]                 mem_wdata,
    input  logic [$clog2(DEPTH)-1:0]   sw_idx,
    output logic [31:0]                sw_addr_word,
    output logic [31:0]                sw_stat_word,
    input  logic                       sw_free,
    input  logic                       sw_nobuf_clr,
    output logic                       nobuf
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             close_en;
    logic [IDX_W-1:0] close_idx;
    logic [31:0]      close_stat;
    logic [DEPTH-1:0] used_vec;
    logic [DEPTH-1:0] wrap_vec;

    rxr_fill_fsm #(
        .DEPTH(DEPTH), .BUF_BYTES(BUF_BYTES), .BASE_ADDR(BASE_ADDR),
        .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .s_valid(s_valid), .s_data(s_data), .s_sof(s_sof),
        .s_eof(s_eof), .s_err(s_err),
        .used_vec(used_vec), .wrap_vec(wrap_vec), .nobuf_clr(sw_nobuf_clr),
        .close_en(close_en), .close_idx(close_idx), .close_stat(close_stat),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .nobuf(nobuf)
    );

    rxr_desc_ring #(
        .DEPTH(DEPTH), .BUF_BYTES(BUF_BYTES), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .close_en(close_en), .close_idx(close_idx), .close_stat(close_stat),
        .free_en(sw_free), .free_idx(sw_idx), .rd_idx(sw_idx),
        .rd_addr_word(sw_addr_word), .rd_stat_word(sw_stat_word),
        .used_vec(used_vec), .wrap_vec(wrap_vec)
    );
endmodule

// File: tb/sim_rxr_ring_writer.sv
`timescale 1ns/1ps
module sim_rxr_ring_writer;
    localparam int D    = 4;
    localparam int BUFB = 128;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, s_err = 1'b0;
    logic [7:0] s_data = '0;
    logic [1:0] sw_idx = '0;
    logic sw_free = 1'b0, sw_nobuf_clr = 1'b0;
    logic mem_we, nobuf;
    logic [31:0] mem_addr, sw_addr_word, sw_stat_word;
    logic [7:0] mem_wdata;

    int checks = 0, failures = 0, cycles = 0;

    always #2.5 clk = ~clk;

    rxr_ring_writer #(.DEPTH(D), .BUF_BYTES(BUFB), .BASE_ADDR(BASE), .LEN_W(13)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .s_valid(s_valid), .s_data(s_data),
        .s_sof(s_sof), .s_eof(s_eof), .s_err(s_err), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sw_idx(sw_idx),
        .sw_addr_word(sw_addr_word), .sw_stat_word(sw_stat_word),
        .sw_free(sw_free), .sw_nobuf_clr(sw_nobuf_clr), .nobuf(nobuf)
    );

    // behavioural reference model
    int m_used [D];
    int m_stat [D];
    int m_wp, m_off, m_len, m_first, m_mode, m_nobuf;
    int e_we, e_addr, e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) begin m_used[i] = 0; m_stat[i] = 0; end
            m_wp = 0; m_off = 0; m_len = 0; m_first = 0; m_mode = 0; m_nobuf = 0;
            e_we = 0; e_addr = 0; e_data = 0;
        end else begin
            e_we = 0;
            if (sw_free) m_used[sw_idx] = 0;
            if (sw_nobuf_clr) m_nobuf = 0;
            if (!rx_en) begin
                m_mode = 0; m_wp = 0; m_off = 0;
            end else if (s_valid) begin
                if (m_mode == 2) begin
                    if (s_eof) m_mode = 0;
                end else if (m_mode == 1 || s_sof) begin
                    if (m_mode == 0) begin m_len = 0; m_first = 1; end
                    if (m_off == 0 && m_used[m_wp] != 0) begin
                        m_nobuf = 1;
                        m_mode = s_eof ? 0 : 2;
                    end else begin
                        e_we = 1; e_addr = BASE + m_wp * BUFB + m_off; e_data = s_data;
                        m_len++; m_off++;
                        m_mode = 1;
                        if (s_eof || m_off == BUFB) begin
                            m_stat[m_wp] = (m_first << 14);
                            if (s_eof) m_stat[m_wp] |= (1 << 15) | (int'(s_err) << 13) | m_len;
                            m_used[m_wp] = 1;
                            m_wp = (m_wp == D - 1) ? 0 : m_wp + 1;
                            m_off = 0; m_first = 0;
                            if (s_eof) m_mode = 0;
                        end
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(mem_we) != e_we || (e_we != 0 &&
                (int'(mem_addr) != e_addr || int'(mem_wdata) != e_data))) begin
                failures++;
                $display("FAIL R2/R6 write: we=%0d addr=%h data=%h expected we=%0d addr=%h data=%h",
                         mem_we, mem_addr, mem_wdata, e_we, e_addr, e_data);
            end
            checks++;
            if (int'(nobuf) != m_nobuf) begin
                failures++;
                $display("FAIL R7 nobuf: got %0d expected %0d", nobuf, m_nobuf);
            end
        end
    end

    task automatic check_ring(input string tag);
        for (int i = 0; i < D; i++) begin
            int ea;
            sw_idx = 2'(i);
            #0.2;
            ea = BASE + i * BUFB + ((i == D - 1) ? 2 : 0) + m_used[i];
            checks++;
            if (int'(sw_addr_word) != ea || int'(sw_stat_word) != m_stat[i]) begin
                failures++;
                $display("FAIL %s desc%0d: addr=%h stat=%h expected addr=%h stat=%h",
                         tag, i, sw_addr_word, sw_stat_word, ea, m_stat[i]);
            end
        end
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            s_valid = 0; s_sof = 0; s_eof = 0; s_err = 0;
            sw_free = 0; sw_nobuf_clr = 0;
        end
    endtask

    task automatic send(input int len, input bit err, input bit with_eof, input int seed);
        for (int k = 0; k < len; k++) begin
            if (k % 7 == 6) idle(1);
            @(negedge clk);
            s_valid = 1; s_data = 8'((k * 13 + seed) & 8'hff);
            s_sof = (k == 0); s_eof = with_eof && (k == len - 1);
            s_err = err && (k == len - 1);
        end
        idle(2);
    endtask

    task automatic free_desc(input int i);
        @(negedge clk);
        sw_idx = 2'(i); sw_free = 1;
        idle(1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_ring("R1 reset");
        check_val("R1 nobuf reset", int'(nobuf), 0);
        rx_en = 1;
        idle(2);

        send(10, 0, 1, 1);                 // R2 R4 single-buffer frame in desc0
        check_ring("R4 short frame");
        send(300, 0, 1, 2);                // R3 R4 frame over desc1..3
        check_ring("R3 multi-buffer frame");
        send(40, 0, 1, 3);                 // R6 desc0 still owned
        check_val("R6 nobuf raised", int'(nobuf), 1);
        check_ring("R6 ring untouched");
        idle(5);
        check_val("R7 nobuf sticky", int'(nobuf), 1);
        @(negedge clk); sw_nobuf_clr = 1; idle(1);
        check_val("R7 nobuf cleared", int'(nobuf), 0);

        free_desc(0); free_desc(1); free_desc(2);
        check_ring("R9 free");             // status words kept
        send(200, 1, 1, 4);                // R8 error frame, R6 resumes at desc0
        check_ring("R8 error frame");
        free_desc(3); free_desc(0);
        send(300, 0, 1, 5);                // R5 desc2,3 then wrap to desc0
        check_ring("R5 wrap straddle");

        for (int i = 0; i < D; i++) free_desc(i);
        for (int k = 0; k < 5; k++) begin  // R11 stray beats
            @(negedge clk); s_valid = 1; s_sof = 0; s_data = 8'(k);
        end
        idle(2);
        check_ring("R11 stray beats");

        send(50, 0, 0, 6);                 // R10 frame in progress at desc1
        @(negedge clk); rx_en = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); s_valid = 1; s_sof = (k == 0); s_eof = (k == 3); s_data = 8'(k);
        end
        idle(1);
        rx_en = 1;
        idle(1);
        send(5, 0, 1, 7);                  // R10 restarts at desc0
        check_ring("R10 disable restart");
        check_val("R10 desc0 length", int'(m_stat[0] & 32'h1fff), 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule